// File: doc/BRIEF.md
# Tag-Propagating Logic Gate Unit

This unit is the shadow-logic evaluator used for information-flow tracking. Every data bit that enters it carries a vector of tag bits, each naming a kind of information (key material, overflow marks and so on). For the two-input operation chosen by the opcode, the unit produces the ordinary one-bit result. It also produces the set of tags on that result. A tag crosses the gate only when its input could actually change the output, given the value of the other input.

A compile-time map puts tags into groups. Tags that share a group cannot block one another. After propagation, an edit stage can force one chosen tag present or absent on the result. A query port then reports whether a second chosen tag is present. The result value, result tags and query bit are captured in a register on each valid input. A valid flag one cycle later marks them.

Top module: `tagprop_unit`

## Requirements
- R1: Opcode 2'b00 is AND. The result value is a AND b. A tag on one input reaches the result only if the other input's value is 1, or if group sharing applies (R4).
- R2: Opcode 2'b01 is OR. The result value is a OR b. A tag on one input reaches the result only if the other input's value is 0, or if group sharing applies (R4).
- R3: Opcode 2'b10 is XOR. The result value is a XOR b, and every tag on either input always reaches the result. This holds even for a self-cancelling pair such as a XOR a, where the value is 0 but the tags remain.
- R4: With the default map, tags 0, 1 and 2 form one group, tags 5 and 6 form a second group, and tags 3, 4 and 7 each stand alone. A tag on one input reaches the result whenever the other input carries any tag of the same group, whatever the other input's value.
- R5: A tag whose group matches no tag on the other input remains subject to the value blocking of R1 and R2.
- R6: When edit_set is 1, tag number edit_sel is present on the result. The result value and all other tags are unchanged by the edit.
- R7: When edit_set is 0 and edit_clr is 1, tag number edit_sel is absent from the result. With both at 0, the tag keeps its propagated state.
- R8: qry_hit is 1 exactly when tag number qry_sel is present on the edited result tags. The result value has no influence on it.
- R9: Opcode 2'b11 is the worst case. The result value is 0, and all tags from both inputs reach the result before the edit stage.
- R10: Results are captured on a rising clock edge when in_valid is 1. out_valid equals the in_valid of the previous cycle. While in_valid is 0, res_val, res_tags and qry_hit hold their values.
- R11: A synchronous active-high reset clears out_valid, res_val, res_tags and qry_hit, even if in_valid is 1 at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture the current operation |
| op | input | 2 | Operation: 00 AND, 01 OR, 10 XOR, 11 worst case |
| a_val | input | 1 | Data value of input a |
| a_tags | input | NTAG | Tag set of input a |
| b_val | input | 1 | Data value of input b |
| b_tags | input | NTAG | Tag set of input b |
| edit_sel | input | SELW | Tag index targeted by the edit stage |
| edit_set | input | 1 | Force the selected tag present (priority) |
| edit_clr | input | 1 | Force the selected tag absent |
| qry_sel | input | SELW | Tag index reported on qry_hit |
| out_valid | output | 1 | Registered results are from the previous valid cycle |
| res_val | output | 1 | Registered result value |
| res_tags | output | NTAG | Registered result tag set |
| qry_hit | output | 1 | Registered presence of the queried tag |

## Verification
Each gate is driven with every combination of the other input's value, with one tag on the side being observed. This separates open lanes from blocked lanes for AND, OR and XOR. Group cases pair a blocked tag with a same-group tag on the other side, then with a foreign-group tag. This tells the group override apart from the plain value rule. Edit cases raise set and clear together and then apart, and each case queries a tag, so set priority, clearing and the query's independence from the value are all seen at the ports.

// File: rtl/tagprop_pkg.sv
package tagprop_pkg;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_XOR = 2'b10,
    OP_ANY = 2'b11
  } tag_op_e;

  // Plain value result of the gate; the worst-case code yields 0.
  function automatic logic gate_value(tag_op_e op, logic a, logic b);
    case (op)
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return 1'b0;
    endcase
  endfunction

  // Does the other input's value let a tag through on this side?
  function automatic logic lane_open(tag_op_e op, logic other_val);
    case (op)
      OP_AND:  return other_val;
      OP_OR:   return ~other_val;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/tag_group_mask.sv
module tag_group_mask #(
  parameter int NTAG = 8,
  parameter int GW   = 3,
  parameter logic [NTAG*GW-1:0] GROUP_MAP = '0
) (
  output logic [NTAG-1:0][NTAG-1:0] peers
);
  // peers[i][j] is 1 when tags i and j share a group.
  for (genvar i = 0; i < NTAG; i++) begin : g_row
    for (genvar j = 0; j < NTAG; j++) begin : g_col
      assign peers[i][j] = (GROUP_MAP[i*GW +: GW] == GROUP_MAP[j*GW +: GW]);
    end
  end
endmodule

// File: rtl/tag_flow_core.sv
module tag_flow_core
  import tagprop_pkg::*;
#(
  parameter int NTAG = 8
) (
  input  tag_op_e                   op,
  input  logic                      a_val,
  input  logic [NTAG-1:0]           a_tags,
  input  logic                      b_val,
  input  logic [NTAG-1:0]           b_tags,
  input  logic [NTAG-1:0][NTAG-1:0] peers,
  output logic                      y_val,
  output logic [NTAG-1:0]           fwd_a,
  output logic [NTAG-1:0]           fwd_b,
  output logic [NTAG-1:0]           y_tags
);
  logic open_a, open_b;

  assign y_val  = gate_value(op, a_val, b_val);
  assign open_a = lane_open(op, b_val);
  assign open_b = lane_open(op, a_val);

  for (genvar i = 0; i < NTAG; i++) begin : g_lane
    logic rescue_a, rescue_b;
    // A same-group tag on the far side cannot block this one.
    assign rescue_a = |(b_tags & peers[i]);
    assign rescue_b = |(a_tags & peers[i]);
    assign fwd_a[i] = a_tags[i] & (open_a | rescue_a);
    assign fwd_b[i] = b_tags[i] & (open_b | rescue_b);
  end

  assign y_tags = fwd_a | fwd_b;
endmodule

// File: rtl/tag_edit_stage.sv
module tag_edit_stage #(
  parameter int NTAG = 8,
  parameter int SELW = 3
) (
  input  logic [NTAG-1:0] tags_in,
  input  logic [SELW-1:0] sel,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic [SELW-1:0] qsel,
  output logic [NTAG-1:0] tags_out,
  output logic            hit
);
  logic [NTAG-1:0] qmask;

  for (genvar i = 0; i < NTAG; i++) begin : g_bit
    logic here;
    assign here        = (sel == SELW'(i));
    assign tags_out[i] = here ? (set_en | (tags_in[i] & ~clr_en)) : tags_in[i];
    assign qmask[i]    = (qsel == SELW'(i));
  end

  assign hit = |(tags_out & qmask);
endmodule

// File: rtl/tagprop_unit.sv
module tagprop_unit
  import tagprop_pkg::*;
#(
  parameter int NTAG = 8,
  parameter int GW   = 3,
  parameter logic [NTAG*GW-1:0] GROUP_MAP =
    {3'd4, 3'd3, 3'd3, 3'd2, 3'd1, 3'd0, 3'd0, 3'd0},
  localparam int SELW = $clog2(NTAG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      op,
  input  logic            a_val,
  input  logic [NTAG-1:0] a_tags,
  input  logic            b_val,
  input  logic [NTAG-1:0] b_tags,
  input  logic [SELW-1:0] edit_sel,
  input  logic            edit_set,
  input  logic            edit_clr,
  input  logic [SELW-1:0] qry_sel,
  output logic            out_valid,
  output logic            res_val,
  output logic [NTAG-1:0] res_tags,
  output logic            qry_hit
);
  logic [NTAG-1:0][NTAG-1:0] peers;
  logic                      y_val;
  logic [NTAG-1:0]           fwd_a, fwd_b, y_tags, edit_tags;
  logic                      edit_hit;

  tag_group_mask #(.NTAG(NTAG), .GW(GW), .GROUP_MAP(GROUP_MAP)) u_mask (
    .peers(peers)
  );

  tag_flow_core #(.NTAG(NTAG)) u_core (
    .op(tag_op_e'(op)), .a_val(a_val), .a_tags(a_tags),
    .b_val(b_val), .b_tags(b_tags), .peers(peers),
    .y_val(y_val), .fwd_a(fwd_a), .fwd_b(fwd_b), .y_tags(y_tags)
  );

  tag_edit_stage #(.NTAG(NTAG), .SELW(SELW)) u_edit (
    .tags_in(y_tags), .sel(edit_sel), .set_en(edit_set), .clr_en(edit_clr),
    .qsel(qry_sel), .tags_out(edit_tags), .hit(edit_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_val   <= 1'b0;
      res_tags  <= '0;
      qry_hit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_val  <= y_val;
        res_tags <= edit_tags;
        qry_hit  <= edit_hit;
      end
    end
  end
endmodule

// File: rtl/tagprop_unit_chk.sv
module tagprop_unit_chk #(
  parameter int NTAG = 8,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      op,
  input logic            a_val,
  input logic [NTAG-1:0] a_tags,
  input logic            b_val,
  input logic [NTAG-1:0] b_tags,
  input logic [SELW-1:0] edit_sel,
  input logic            edit_set,
  input logic            edit_clr,
  input logic [SELW-1:0] qry_sel,
  input logic            out_valid,
  input logic            res_val,
  input logic [NTAG-1:0] res_tags,
  input logic            qry_hit
);
  logic no_edit;
  assign no_edit = !edit_set && !edit_clr;

  assert_and_block_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 2'b00 && !b_val && b_tags == '0 && no_edit
    |=> res_tags == '0 && !res_val);

  assert_or_block_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 2'b01 && b_val && b_tags == '0 && no_edit
    |=> res_tags == '0 && res_val);

  assert_xor_all_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 2'b10 && no_edit
    |=> res_tags == ($past(a_tags) | $past(b_tags)) && res_val == ($past(a_val) ^ $past(b_val)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && edit_set |=> res_tags[$past(edit_sel)]);

  assert_clr_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && !edit_set && edit_clr |=> !res_tags[$past(edit_sel)]);

  assert_query_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> qry_hit == res_tags[$past(qry_sel)]);

  assert_fallback_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 2'b11 && no_edit
    |=> !res_val && res_tags == ($past(a_tags) | $past(b_tags)));

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drop_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_val) && $stable(res_tags) && $stable(qry_hit));
endmodule

bind tagprop_unit tagprop_unit_chk #(.NTAG(NTAG), .SELW(SELW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .a_val(a_val), .a_tags(a_tags), .b_val(b_val), .b_tags(b_tags),
  .edit_sel(edit_sel), .edit_set(edit_set), .edit_clr(edit_clr),
  .qry_sel(qry_sel), .out_valid(out_valid), .res_val(res_val),
  .res_tags(res_tags), .qry_hit(qry_hit)
);

// File: tb/tagprop_unit_bench.sv
module tagprop_unit_bench;
  localparam int NT = 8;
  localparam int GRP [NT] = '{0, 0, 0, 1, 2, 3, 3, 4};

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [1:0] op;
  logic a_val, b_val;
  logic [NT-1:0] a_tags, b_tags;
  logic [2:0] edit_sel, qry_sel;
  logic edit_set, edit_clr;
  logic out_valid, res_val, qry_hit;
  logic [NT-1:0] res_tags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tagprop_unit u_tagprop_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .a_val(a_val), .a_tags(a_tags), .b_val(b_val), .b_tags(b_tags),
    .edit_sel(edit_sel), .edit_set(edit_set), .edit_clr(edit_clr),
    .qry_sel(qry_sel), .out_valid(out_valid), .res_val(res_val),
    .res_tags(res_tags), .qry_hit(qry_hit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: a tag on one side survives if that side can sway the
  // output, or if the far side holds any tag of the same group.
  function automatic logic [NT-1:0] ref_tags(int o, bit av, logic [NT-1:0] at,
                                             bit bv, logic [NT-1:0] bt);
    logic [NT-1:0] r = '0;
    for (int i = 0; i < NT; i++) begin
      bit pa = (o >= 2) || (o == 0 && bv) || (o == 1 && !bv);
      bit pb = (o >= 2) || (o == 0 && av) || (o == 1 && !av);
      for (int j = 0; j < NT; j++) begin
        if (bt[j] && GRP[j] == GRP[i]) pa = 1;
        if (at[j] && GRP[j] == GRP[i]) pb = 1;
      end
      r[i] = (at[i] && pa) || (bt[i] && pb);
    end
    return r;
  endfunction

  function automatic bit ref_val(int o, bit av, bit bv);
    if (o == 0) return av & bv;
    if (o == 1) return av | bv;
    if (o == 2) return av ^ bv;
    return 1'b0;
  endfunction

  task automatic apply(string req, int o, bit av, logic [NT-1:0] at, bit bv,
                       logic [NT-1:0] bt, int sel, bit st, bit cl, int qs);
    logic [NT-1:0] et;
    @(negedge clk);
    in_valid = 1; op = 2'(o); a_val = av; a_tags = at; b_val = bv; b_tags = bt;
    edit_sel = 3'(sel); edit_set = st; edit_clr = cl; qry_sel = 3'(qs);
    @(negedge clk);
    in_valid = 0;
    et = ref_tags(o, av, at, bv, bt);
    if (st) et[sel] = 1'b1;
    else if (cl) et[sel] = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " value"}, 32'(res_val), 32'(ref_val(o, av, bv)));
    check({req, " tags"}, 32'(res_tags), 32'(et));
    check({req, " query"}, 32'(qry_hit), 32'(et[qs]));
  endtask

  task automatic t_reset_R11();
    rst = 1; in_valid = 1; op = 2'b10; a_val = 1; a_tags = '1; b_val = 0; b_tags = '1;
    edit_sel = 0; edit_set = 1; edit_clr = 0; qry_sel = 0;
    repeat (3) @(negedge clk);
    check("R11 valid", 32'(out_valid), 0);
    check("R11 value", 32'(res_val), 0);
    check("R11 tags", 32'(res_tags), 0);
    check("R11 query", 32'(qry_hit), 0);
    rst = 0; in_valid = 0; edit_set = 0;
  endtask

  task automatic t_and_R1();
    apply("R1 b=1 opens a", 0, 0, 8'h10, 1, 8'h00, 0, 0, 0, 4);
    apply("R1 b=0 blocks a", 0, 1, 8'h10, 0, 8'h00, 0, 0, 0, 4);
    apply("R1 a=0 blocks b", 0, 0, 8'h00, 1, 8'h80, 0, 0, 0, 7);
    apply("R1 both 1", 0, 1, 8'h08, 1, 8'h80, 0, 0, 0, 3);
  endtask

  task automatic t_or_R2();
    apply("R2 b=0 opens a", 1, 1, 8'h10, 0, 8'h00, 0, 0, 0, 4);
    apply("R2 b=1 blocks a", 1, 0, 8'h10, 1, 8'h00, 0, 0, 0, 4);
    apply("R2 both 0", 1, 0, 8'h08, 0, 8'h80, 0, 0, 0, 7);
  endtask

  task automatic t_xor_R3();
    apply("R3 mixed", 2, 1, 8'h18, 0, 8'h81, 0, 0, 0, 0);
    apply("R3 self cancel", 2, 1, 8'h24, 1, 8'h24, 0, 0, 0, 5);
  endtask

  task automatic t_group_R4_R5();
    apply("R4 AND same group", 0, 0, 8'h01, 0, 8'h02, 0, 0, 0, 0);
    apply("R4 OR same group", 1, 1, 8'h20, 1, 8'h40, 0, 0, 0, 6);
    apply("R5 AND foreign group", 0, 0, 8'h09, 0, 8'h02, 0, 0, 0, 3);
    apply("R5 OR foreign group", 1, 1, 8'h10, 1, 8'h20, 0, 0, 0, 4);
  endtask

  task automatic t_edit_R6_R7();
    apply("R6 set over clr", 0, 0, 8'h00, 0, 8'h00, 3, 1, 1, 3);
    apply("R6 set keeps rest", 2, 1, 8'h81, 0, 8'h00, 4, 1, 0, 7);
    apply("R7 clr", 2, 0, 8'h81, 1, 8'h02, 7, 0, 1, 7);
    apply("R7 no edit", 2, 0, 8'h81, 0, 8'h00, 7, 0, 0, 7);
  endtask

  task automatic t_query_R8();
    apply("R8 value 1 tag absent", 1, 1, 8'h00, 1, 8'h00, 0, 0, 0, 2);
    apply("R8 value 0 tag present", 2, 1, 8'h04, 1, 8'h00, 0, 0, 0, 2);
  endtask

  task automatic t_fallback_R9();
    apply("R9 worst case", 3, 1, 8'h11, 1, 8'h60, 0, 0, 0, 6);
    apply("R9 with clr", 3, 0, 8'h11, 0, 8'h60, 0, 0, 1, 0);
  endtask

  task automatic t_hold_R10();
    logic [NT-1:0] kept_tags;
    logic kept_val, kept_hit;
    apply("R10 load", 2, 1, 8'h5a, 0, 8'h00, 0, 0, 0, 1);
    kept_tags = res_tags; kept_val = res_val; kept_hit = qry_hit;
    op = 2'b11; a_tags = '1; b_tags = '1; a_val = 0; b_val = 0; edit_set = 1; qry_sel = 0;
    repeat (2) @(negedge clk);
    check("R10 valid low", 32'(out_valid), 0);
    check("R10 hold tags", 32'(res_tags), 32'(kept_tags));
    check("R10 hold value", 32'(res_val), 32'(kept_val));
    check("R10 hold query", 32'(qry_hit), 32'(kept_hit));
    edit_set = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_R11();
    t_and_R1();
    t_or_R2();
    t_xor_R3();
    t_group_R4_R5();
    t_edit_R6_R7();
    t_query_R8();
    t_fallback_R9();
    t_hold_R10();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule